// File: doc/BRIEF.md
# Pulse and Duty-Cycle Capture Unit

This block times an external digital signal against the local clock. In pulse mode it reports how many clock cycles one active pulse lasted. In duty mode it reports two values for each period of the signal: the length of the active part and the length of the whole period, measured from one start edge to the next. A configuration bit chooses which level counts as active, and therefore which edge starts a measurement. A second bit chooses whether measurements repeat or whether the engine stops after the first result.

The asynchronous input first passes a two-flop synchronizer and an edge detector. A small state machine then drives a saturating counter. Its states are OFF (disabled, counter held at zero), ARMED (waiting for a start edge), ACTIVE (counting the active phase), REST (duty mode only, counting the inactive phase) and HELD (single mode, finished). The transitions are:

- OFF→ARMED when enabled.
- ARMED→ACTIVE on a start edge.
- ACTIVE→ARMED on an end edge in pulse loop mode.
- ACTIVE→REST on an end edge in duty mode.
- ACTIVE→HELD on an end edge in pulse single mode.
- REST→ACTIVE on a start edge in duty loop mode.
- REST→HELD on a start edge in duty single mode.
- Any state→OFF when the enable drops.

Each completed capture sets an interrupt status bit. A capture that completes while that bit is still set raises an overflow bit. A read strobe on the running count clears both bits.

Top module: `sig_meter`

## Requirements
- R1: With `start_low`=0 in pulse mode, `pulse_width` becomes the number of clock cycles that `sig_in` was high. When the input changes on clock boundaries this count is exact. The result appears within four cycles of the falling edge.
- R2: With `start_low`=1 the active level is low, so a falling edge starts the measurement and `pulse_width` reports the number of cycles the input was low.
- R3: In duty mode (`duty_mode`=1), `cycle_width` becomes the high plus low cycle count of one period and `pulse_width` the active part of that period. Both are published together when the next start edge is seen. Neither changes while a period is still being measured.
- R4: With `one_shot`=0 captures repeat for every pulse or period. With `one_shot`=1 exactly one capture is made, and later edges change neither the results nor the interrupt status until `enable` is dropped and raised again.
- R5: When `irq_en`=1, every completed capture sets `irq_raw`, and `irq` equals `irq_raw` AND `irq_unmask`. When `irq_en`=0 a capture still updates the results but leaves `irq_raw` low.
- R6: When a capture completes while `irq_raw` is already set, `irq_ovf` is set. `irq_ovf` is never high while `irq_raw` is low.
- R7: A one-cycle `cnt_rd` strobe clears `irq_raw` and `irq_ovf` in the next cycle. If a capture completes in the same cycle as the strobe, `irq_raw` ends set and `irq_ovf` ends clear.
- R8: `cur_count` shows the running count during a measurement, starting at 1 in the first synchronized active cycle. The counter saturates at all ones (2^CNT_W−1) and does not wrap, and a saturated measurement reports all ones.
- R9: While `enable` is low the engine is in OFF, `cur_count` reads zero, and the last published results are kept.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that is counted |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the engine; low returns it to OFF |
| duty_mode | input | 1 | 0 = pulse mode, 1 = duty mode |
| start_low | input | 1 | 0 = high is active (rising starts), 1 = low is active (falling starts) |
| one_shot | input | 1 | 0 = loop, 1 = single capture |
| irq_en | input | 1 | Allows captures to set the interrupt status |
| irq_unmask | input | 1 | Passes the raw status to `irq` |
| sig_in | input | 1 | Asynchronous signal being measured |
| cnt_rd | input | 1 | Read strobe of the running count; clears the status bits |
| cur_count | output | CNT_W | Running measurement count |
| pulse_width | output | CNT_W | Active-phase width result |
| cycle_width | output | CNT_W | Full period width result (duty mode) |
| irq_raw | output | 1 | Interrupt status before masking |
| irq_ovf | output | 1 | Capture completed while status was still set |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that `duty_mode`, `start_low` and `one_shot` are changed only while `enable` is low. Changing the polarity during a measurement would create false edges after the synchronizer. They also assume that `cnt_rd` is a strobe from a reader that acts on whatever status it finds. The stimulus changes configuration only after dropping `enable` and lets the input settle before raising it again. It drives `sig_in` on the falling clock edge so that synchronized widths are exact. In duty mode it holds each active phase for at least eight cycles, so the results of one period can be sampled before the next period closes.

// File: rtl/sig_meter_pkg.sv
package sig_meter_pkg;

    // Engine states of the capture controller
    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_ARMED  = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_REST   = 3'd3,
        ST_HELD   = 3'd4
    } meter_state_e;

    // Measurement kinds selected by the duty_mode input
    typedef enum logic {
        KIND_PULSE = 1'b0,
        KIND_DUTY  = 1'b1
    } meter_kind_e;

endpackage

// File: rtl/sig_meter_sync.sv
module sig_meter_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_async,
    input  logic active_low,
    output logic start_evt,
    output logic end_evt
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] stage_q;
    logic              prev_q;
    logic              level_now;
    logic              level_prev;

    // Synchronizer chain: the first flop samples the asynchronous input
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= sig_async;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    // Delayed copy of the synchronized level, used for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= stage_q[LAST];
        end
    end

    // Fold the polarity in so that the controller always sees "active = 1"
    always_comb begin
        level_now  = stage_q[LAST] ^ active_low;
        level_prev = prev_q ^ active_low;
        start_evt  = level_now & ~level_prev;
        end_evt    = ~level_now & level_prev;
    end

endmodule

// File: rtl/sig_meter_fsm.sv
module sig_meter_fsm
    import sig_meter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             duty_mode,
    input  logic             one_shot,
    input  logic             start_evt,
    input  logic             end_evt,
    output logic [CNT_W-1:0] cur_count,
    output logic [CNT_W-1:0] pulse_width,
    output logic [CNT_W-1:0] cycle_width,
    output logic             cap_done
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    meter_state_e     state_q;
    meter_state_e     state_d;
    meter_kind_e      kind;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic [CNT_W-1:0] active_hold_q;
    logic [CNT_W-1:0] pulse_q;
    logic [CNT_W-1:0] cycle_q;

    assign kind = meter_kind_e'(duty_mode);

    // Saturating increment of the running count
    assign count_inc = (count_q == CNT_MAX) ? count_q : count_q + CNT_ONE;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (start_evt) begin
                        state_d = ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    if (end_evt) begin
                        if (kind == KIND_DUTY) begin
                            state_d = ST_REST;
                        end else if (one_shot) begin
                            state_d = ST_HELD;
                        end else begin
                            state_d = ST_ARMED;
                        end
                    end
                end
                ST_REST: begin
                    if (start_evt) begin
                        state_d = one_shot ? ST_HELD : ST_ACTIVE;
                    end
                end
                ST_HELD: begin
                    state_d = ST_HELD;
                end
                default: begin
                    state_d = ST_OFF;
                end
            endcase
        end
    end

    // A capture closes in this cycle; results publish at the coming edge
    always_comb begin
        cap_done = 1'b0;
        if (enable) begin
            if (state_q == ST_ACTIVE && end_evt && kind == KIND_PULSE) begin
                cap_done = 1'b1;
            end
            if (state_q == ST_REST && start_evt) begin
                cap_done = 1'b1;
            end
        end
    end

    // Counter and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q       <= '0;
            active_hold_q <= '0;
            pulse_q       <= '0;
            cycle_q       <= '0;
        end else if (!enable) begin
            count_q <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    count_q <= '0;
                end
                ST_ARMED: begin
                    if (start_evt) begin
                        count_q <= CNT_ONE;
                    end
                end
                ST_ACTIVE: begin
                    if (end_evt) begin
                        if (kind == KIND_DUTY) begin
                            // keep the active width in a shadow until the period closes
                            active_hold_q <= count_q;
                            count_q       <= count_inc;
                        end else begin
                            pulse_q <= count_q;
                        end
                    end else begin
                        count_q <= count_inc;
                    end
                end
                ST_REST: begin
                    if (start_evt) begin
                        // publish both results together
                        pulse_q <= active_hold_q;
                        cycle_q <= count_q;
                        count_q <= CNT_ONE;
                    end else begin
                        count_q <= count_inc;
                    end
                end
                ST_HELD: begin
                    count_q <= count_q;
                end
                default: begin
                    count_q <= '0;
                end
            endcase
        end
    end

    assign cur_count   = count_q;
    assign pulse_width = pulse_q;
    assign cycle_width = cycle_q;

endmodule

// File: rtl/sig_meter_irq.sv
module sig_meter_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_done,
    input  logic irq_en,
    input  logic irq_unmask,
    input  logic clear,
    output logic irq_raw,
    output logic irq_ovf,
    output logic irq
);

    logic raw_q;
    logic ovf_q;
    logic set_evt;

    assign set_evt = cap_done & irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            ovf_q <= 1'b0;
        end else if (clear) begin
            // a capture closing together with the read survives it
            raw_q <= set_evt;
            ovf_q <= 1'b0;
        end else if (set_evt) begin
            ovf_q <= ovf_q | raw_q;
            raw_q <= 1'b1;
        end
    end

    assign irq_raw = raw_q;
    assign irq_ovf = ovf_q;
    assign irq     = raw_q & irq_unmask;

endmodule

// File: rtl/sig_meter.sv
module sig_meter #(
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             duty_mode,
    input  logic             start_low,
    input  logic             one_shot,
    input  logic             irq_en,
    input  logic             irq_unmask,
    input  logic             sig_in,
    input  logic             cnt_rd,
    output logic [CNT_W-1:0] cur_count,
    output logic [CNT_W-1:0] pulse_width,
    output logic [CNT_W-1:0] cycle_width,
    output logic             irq_raw,
    output logic             irq_ovf,
    output logic             irq
);

    logic start_evt;
    logic end_evt;
    logic cap_done;

    sig_meter_sync #(
        .STAGES(SYNC_DEPTH)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_async (sig_in),
        .active_low(start_low),
        .start_evt (start_evt),
        .end_evt   (end_evt)
    );

    sig_meter_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .duty_mode  (duty_mode),
        .one_shot   (one_shot),
        .start_evt  (start_evt),
        .end_evt    (end_evt),
        .cur_count  (cur_count),
        .pulse_width(pulse_width),
        .cycle_width(cycle_width),
        .cap_done   (cap_done)
    );

    sig_meter_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_done  (cap_done),
        .irq_en    (irq_en),
        .irq_unmask(irq_unmask),
        .clear     (cnt_rd),
        .irq_raw   (irq_raw),
        .irq_ovf   (irq_ovf),
        .irq       (irq)
    );

endmodule

// File: rtl/sig_meter_checker.sv
module sig_meter_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             irq_en,
    input logic             cnt_rd,
    input logic             cap_done,
    input logic [CNT_W-1:0] cur_count,
    input logic [CNT_W-1:0] pulse_width,
    input logic [CNT_W-1:0] cycle_width,
    input logic             irq_raw,
    input logic             irq_ovf,
    input logic             irq
);

    assert_ovf_needs_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> irq_raw);

    assert_raw_from_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_raw) |-> $past(cap_done));

    assert_no_raw_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !irq_raw) |=> !irq_raw);

    assert_irq_follows_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_raw);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && !cap_done) |=> (!irq_raw && !irq_ovf));

    assert_read_vs_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && cap_done && irq_en) |=> (irq_raw && !irq_ovf));

    assert_results_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_done |=> ($stable(pulse_width) && $stable(cycle_width)));

    assert_off_count_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cur_count == '0));

    assert_count_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cur_count == '1) |=> (cur_count == '1 || cur_count <= CNT_W'(1)));

endmodule

bind sig_meter sig_meter_checker #(
    .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .irq_en     (irq_en),
    .cnt_rd     (cnt_rd),
    .cap_done   (cap_done),
    .cur_count  (cur_count),
    .pulse_width(pulse_width),
    .cycle_width(cycle_width),
    .irq_raw    (irq_raw),
    .irq_ovf    (irq_ovf),
    .irq        (irq)
);

// File: tb/sig_meter_bench.sv
`timescale 1ns/1ps
module sig_meter_bench;

    localparam int CNT_W = 10;
    localparam int LIMIT = 200000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             duty_mode = 1'b0;
    logic             start_low = 1'b0;
    logic             one_shot = 1'b0;
    logic             irq_en = 1'b0;
    logic             irq_unmask = 1'b0;
    logic             sig_in = 1'b0;
    logic             cnt_rd = 1'b0;
    logic [CNT_W-1:0] cur_count;
    logic [CNT_W-1:0] pulse_width;
    logic [CNT_W-1:0] cycle_width;
    logic             irq_raw;
    logic             irq_ovf;
    logic             irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sig_meter #(.CNT_W(CNT_W)) u_sig_meter (
        .clk(clk), .rst_n(rst_n), .enable(enable), .duty_mode(duty_mode),
        .start_low(start_low), .one_shot(one_shot), .irq_en(irq_en),
        .irq_unmask(irq_unmask), .sig_in(sig_in), .cnt_rd(cnt_rd),
        .cur_count(cur_count), .pulse_width(pulse_width), .cycle_width(cycle_width),
        .irq_raw(irq_raw), .irq_ovf(irq_ovf), .irq(irq)
    );

    function automatic int exp_width(int cycles);
        int top = (1 << CNT_W) - 1;
        return (cycles > top) ? top : cycles;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_clear();
        cnt_rd = 1'b1;
        tick(1);
        cnt_rd = 1'b0;
    endtask

    // drive the active level for n cycles, then the idle level for gap cycles
    task automatic pulse(input int n, input int gap);
        sig_in = ~start_low;
        tick(n);
        sig_in = start_low;
        tick(gap);
    endtask

    task automatic rearm();
        enable = 1'b0;
        sig_in = start_low;
        tick(4);
        enable = 1'b1;
        tick(2);
    endtask

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        tick(4);
        chk("R10 pulse_width", int'(pulse_width), 0);
        chk("R10 cycle_width", int'(cycle_width), 0);
        chk("R10 cur_count", int'(cur_count), 0);
        chk("R10 irq_raw", int'(irq_raw), 0);
        chk("R10 irq_ovf", int'(irq_ovf), 0);
        chk("R10 irq", int'(irq), 0);
        rst_n = 1'b1;
        irq_en = 1'b1;
        irq_unmask = 1'b1;
        rearm();

        // R1 random pulse widths, loop mode
        for (int i = 0; i < 8; i++) begin
            int h = 1 + int'($urandom % 30);
            rd_clear();
            pulse(h, 8);
            chk("R1 pulse width", int'(pulse_width), h);
            chk("R8 count after pulse", int'(cur_count), h);
            chk("R5 raw set", int'(irq_raw), 1);
            chk("R5 irq unmasked", int'(irq), 1);
            chk("R6 no overflow", int'(irq_ovf), 0);
        end

        // R7 read clears
        rd_clear();
        chk("R7 raw cleared", int'(irq_raw), 0);
        chk("R7 ovf cleared", int'(irq_ovf), 0);

        // R6 overflow
        pulse(5, 8);
        pulse(7, 8);
        chk("R6 ovf set", int'(irq_ovf), 1);
        chk("R6 raw kept", int'(irq_raw), 1);
        chk("R4 loop second result", int'(pulse_width), 7);
        rd_clear();
        chk("R7 ovf cleared after overflow", int'(irq_ovf), 0);

        // R7 read in the closing cycle of a capture, raw already set
        pulse(3, 8);
        sig_in = 1'b1;
        tick(6);
        sig_in = 1'b0;
        tick(2);
        cnt_rd = 1'b1;
        tick(1);
        cnt_rd = 1'b0;
        chk("R7 capture wins raw", int'(irq_raw), 1);
        chk("R7 capture wins ovf", int'(irq_ovf), 0);
        chk("R7 capture result", int'(pulse_width), 6);

        // R5 masking and disable
        irq_unmask = 1'b0;
        rd_clear();
        pulse(4, 8);
        chk("R5 raw with mask", int'(irq_raw), 1);
        chk("R5 irq masked", int'(irq), 0);
        irq_unmask = 1'b1;
        tick(1);
        chk("R5 irq after unmask", int'(irq), 1);
        irq_en = 1'b0;
        rd_clear();
        pulse(6, 8);
        chk("R5 no raw when disabled", int'(irq_raw), 0);
        chk("R5 result still captured", int'(pulse_width), 6);
        irq_en = 1'b1;

        // R9 disable keeps results, zeroes count
        enable = 1'b0;
        tick(2);
        chk("R9 count zero when off", int'(cur_count), 0);
        chk("R9 result kept when off", int'(pulse_width), 6);

        // R2 low-active pulses
        start_low = 1'b1;
        rearm();
        for (int i = 0; i < 5; i++) begin
            int l = 1 + int'($urandom % 30);
            pulse(l, 8);
            chk("R2 low width", int'(pulse_width), l);
        end

        // R3 duty mode, loop
        start_low = 1'b0;
        duty_mode = 1'b1;
        rearm();
        rd_clear();
        begin
            int hp = 0;
            int lp = 0;
            for (int i = 0; i <= 6; i++) begin
                int h = 8 + int'($urandom % 25);
                int l = 1 + int'($urandom % 25);
                sig_in = 1'b1;
                if (i > 0) begin
                    tick(5);
                    chk("R3 duty pulse", int'(pulse_width), hp);
                    chk("R3 duty cycle", int'(cycle_width), hp + lp);
                    chk("R5 duty raw", int'(irq_raw), 1);
                    tick(h - 5);
                end else begin
                    tick(h);
                end
                if (i == 6) break;
                sig_in = 1'b0;
                tick(l);
                if (i > 0) chk("R3 atomic hold", int'(pulse_width), hp);
                hp = h;
                lp = l;
            end
        end
        chk("R6 duty overflow", int'(irq_ovf), 1);

        // R4 single mode
        duty_mode = 1'b0;
        one_shot = 1'b1;
        rearm();
        rd_clear();
        pulse(9, 8);
        chk("R4 single first", int'(pulse_width), 9);
        chk("R4 single raw", int'(irq_raw), 1);
        rd_clear();
        pulse(13, 8);
        chk("R4 single ignores later", int'(pulse_width), 9);
        chk("R4 single no new raw", int'(irq_raw), 0);
        enable = 1'b0;
        tick(2);
        chk("R9 off count", int'(cur_count), 0);
        chk("R9 off keeps result", int'(pulse_width), 9);
        enable = 1'b1;
        tick(2);
        pulse(11, 8);
        chk("R4 rearmed capture", int'(pulse_width), 11);

        // R8 running count and saturation
        one_shot = 1'b0;
        rearm();
        sig_in = 1'b1;
        tick(10);
        chk("R8 running count", int'(cur_count), 8);
        tick(1090);
        sig_in = 1'b0;
        tick(8);
        chk("R8 saturated width", int'(pulse_width), exp_width(1100));
        chk("R8 saturated count", int'(cur_count), exp_width(1100));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule